// File: doc/BRIEF.md
# Table-Call and Debug-Trap Control Sequencer

This block carries out three kinds of control transfer for a processor core, each as a fixed multi-cycle sequence: an indirect call through a table of halfword offsets, the return from that call, and a debug trap together with its return. The core hands it a one-cycle strobe, a two-bit operation class, a 6-bit table index and its current program counter and status word. The block then runs the sequence and reports the resulting program counter and status word with a one-cycle done pulse.

The block owns the table base register and two save pairs, one for the table call and one for the debug trap. Each pair holds a return address and a saved status word. A table call reads one halfword from memory over a simple request/ready port and adds the value it reads to the table base to form the target. The two returns need no memory access. Each one restores from its own save pair.

Top module: `tcall_dtrap_unit`

## Requirements
- R1: After reset, `done` and `mem_req` are low, `new_pc` and `new_psw` are zero, and the table base holds the parameter `BASE_RST` (default 0).
- R2: A table call (class code 2'b00) stores `cur_pc`+2 with bit 0 cleared as the call return address, and stores `cur_psw` as the call status word. Both values come from the accepting cycle.
- R3: During a table call, `mem_req` is high with `mem_addr` equal to table base + (zero-extended index × 2). It rises in the second cycle after the accepting clock edge and stays high until `mem_ready` is sampled high.
- R4: A table call ends with `new_pc` = table base + zero-extended halfword read, with bit 0 cleared, and `new_psw` equal to the status word saved at acceptance.
- R5: With `mem_ready` high in the first request cycle, a table call's done pulse appears in the 5th cycle after the accepting edge. Each request cycle with `mem_ready` low adds exactly one cycle, and there is exactly one request per call.
- R6: A table return (class code 2'b01) gives `new_pc`/`new_psw` equal to the call save pair, with done in the 4th cycle after acceptance.
- R7: A debug trap (class code 2'b10) stores `cur_pc`+2 with bit 0 cleared and `cur_psw` in the debug save pair. It gives `new_pc` = 0x00000060 and `new_psw` = `cur_psw` with bits 7, 6 and 5 set, with done in the 4th cycle.
- R8: A debug return (class code 2'b11) gives `new_pc`/`new_psw` equal to the debug save pair, with done in the 4th cycle.
- R9: A strobe that arrives while a sequence is running is ignored: no save pair, output or memory access changes. A strobe present in the cycle that `done` is high is accepted.
- R10: `done` is high for exactly one cycle per sequence. `new_pc` and `new_psw` hold their values until the next done pulse, and `new_pc` bit 0 is always zero.
- R11: A high `base_load` writes `base_value` into the table base at the next clock edge. Later table calls use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | Operation class: 00 call, 01 call return, 10 trap, 11 trap return |
| op_index | input | 6 | Table index for a call |
| cur_pc | input | 32 | Current program counter |
| cur_psw | input | 32 | Current status word |
| base_load | input | 1 | Table base write enable |
| base_value | input | 32 | Table base write value |
| mem_req | output | 1 | Halfword read request |
| mem_addr | output | 32 | Read address |
| mem_rdata | input | 16 | Read data, valid when ready |
| mem_ready | input | 1 | Read completes this cycle |
| new_pc | output | 32 | Resulting program counter |
| new_psw | output | 32 | Resulting status word |
| done | output | 1 | One-cycle completion pulse |

## Verification
A strobe can reach the block in the same cycle that the done pulse of the previous sequence is high. It can also arrive during the busy cycles just before that pulse. The bench holds the strobe high through a whole table call, with a trap class during the busy cycles. It then switches to a debug-return class in the done cycle. The result is judged correct when the call completes unchanged, the debug return starts at the next edge and takes exactly four cycles, and the restored debug address shows that none of the ignored trap strobes reached the save pair.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        OP_TCALL = 2'b00,
        OP_TRET  = 2'b01,
        OP_DTRAP = 2'b10,
        OP_DRET  = 2'b11
    } op_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] psw;
    } ctx_t;

    function automatic logic [XLEN-1:0] clr_lsb(input logic [XLEN-1:0] v);
        return {v[XLEN-1:1], 1'b0};
    endfunction

    function automatic logic [XLEN-1:0] ret_addr(input logic [XLEN-1:0] pc);
        return clr_lsb(pc + XLEN'(2));
    endfunction

endpackage

// File: rtl/tcd_sequencer.sv
module tcd_sequencer
    import tcd_pkg::*;
#(
    parameter int CALL_CYCLES = 5,
    parameter int RET_CYCLES  = 4,
    parameter int FETCH_STEP  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic op_valid,
    input  op_e  op_kind,
    input  logic mem_ready,
    output logic accept,
    output op_e  op_q,
    output logic fetch_en,
    output logic add_en,
    output logic finish
);
    localparam int SW = $clog2(CALL_CYCLES + 1);
    localparam logic [SW-1:0] CALL_LAST = SW'(CALL_CYCLES - 1);
    localparam logic [SW-1:0] RET_LAST  = SW'(RET_CYCLES - 1);
    localparam logic [SW-1:0] FETCH_AT  = SW'(FETCH_STEP);
    localparam logic [SW-1:0] ADD_AT    = SW'(FETCH_STEP + 1);

    logic          busy_q;
    logic [SW-1:0] step_q;
    logic [SW-1:0] last_step;
    logic          stall;

    always_comb begin
        last_step = (op_q == OP_TCALL) ? CALL_LAST : RET_LAST;
        accept    = op_valid && !busy_q;
        fetch_en  = busy_q && (op_q == OP_TCALL) && (step_q == FETCH_AT);
        add_en    = busy_q && (op_q == OP_TCALL) && (step_q == ADD_AT);
        stall     = fetch_en && !mem_ready;
        finish    = busy_q && (step_q == last_step) && !stall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            op_q   <= OP_TCALL;
        end else if (accept) begin
            busy_q <= 1'b1;
            step_q <= SW'(1);
            op_q   <= op_kind;
        end else if (busy_q) begin
            if (finish) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else if (!stall) begin
                step_q <= step_q + SW'(1);
            end
        end
    end

    // R5: a request not yet answered stays open in the next cycle
    a_r5_fetch_holds: assert property (@(posedge clk) disable iff (rst)
        fetch_en && !mem_ready |=> fetch_en);

    // R9: the class of a running sequence never changes before it finishes
    a_r9_op_frozen: assert property (@(posedge clk) disable iff (rst)
        busy_q && !finish |=> $stable(op_q));

    generate
        if (RET_CYCLES == 4) begin : g_len_chk
            // R6 R7 R8: non-call sequences end three edges after acceptance
            a_r6_short_len: assert property (@(posedge clk) disable iff (rst)
                finish && (op_q != OP_TCALL) |-> $past(accept, 3));
        end
    endgenerate

endmodule

// File: rtl/tcd_save_bank.sv
module tcd_save_bank
    import tcd_pkg::*;
#(
    parameter logic [31:0] BASE_RST = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  op_e             op_kind,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_psw,
    input  logic            base_load,
    input  logic [XLEN-1:0] base_value,
    output ctx_t            ct_ctx,
    output ctx_t            db_ctx,
    output logic [XLEN-1:0] base_q
);
    localparam int NSLOT = 2;

    ctx_t slot_q [NSLOT];

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            localparam op_e SAVE_OP = (g == 0) ? OP_TCALL : OP_DTRAP;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[g] <= '0;
                end else if (accept && (op_kind == SAVE_OP)) begin
                    slot_q[g].pc  <= ret_addr(cur_pc);
                    slot_q[g].psw <= cur_psw;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RST;
        end else if (base_load) begin
            base_q <= base_value;
        end
    end

    assign ct_ctx = slot_q[0];
    assign db_ctx = slot_q[1];

    // R2: call save pair only moves when a call is accepted
    a_r2_call_pair_hold: assert property (@(posedge clk) disable iff (rst)
        !(accept && op_kind == OP_TCALL) |=> $stable(ct_ctx));

    // R9: debug save pair only moves when a trap is accepted
    a_r9_dbg_pair_hold: assert property (@(posedge clk) disable iff (rst)
        !(accept && op_kind == OP_DTRAP) |=> $stable(db_ctx));

endmodule

// File: rtl/tcd_pc_unit.sv
module tcd_pc_unit
    import tcd_pkg::*;
#(
    parameter int          IDX_W    = 6,
    parameter int          HW_W     = 16,
    parameter logic [31:0] TRAP_VEC = 32'h0000_0060,
    parameter int          NP_BIT   = 7,
    parameter int          EP_BIT   = 6,
    parameter int          ID_BIT   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [IDX_W-1:0] op_index,
    input  op_e              op_q,
    input  logic             fetch_en,
    input  logic             add_en,
    input  logic             finish,
    input  logic             mem_ready,
    input  logic [HW_W-1:0]  mem_rdata,
    input  logic [XLEN-1:0]  base_q,
    input  ctx_t             ct_ctx,
    input  ctx_t             db_ctx,
    output logic [XLEN-1:0]  mem_addr,
    output ctx_t             out_ctx,
    output logic             done
);
    localparam logic [XLEN-1:0] TRAP_MASK =
        (XLEN'(1) << NP_BIT) | (XLEN'(1) << EP_BIT) | (XLEN'(1) << ID_BIT);

    logic [IDX_W-1:0] idx_q;
    logic [HW_W-1:0]  data_q;
    logic [XLEN-1:0]  tgt_q;
    ctx_t             next_ctx;

    assign mem_addr = base_q + {{(XLEN-IDX_W-1){1'b0}}, idx_q, 1'b0};

    always_comb begin
        unique case (op_q)
            OP_TCALL: next_ctx = '{pc: tgt_q,       psw: ct_ctx.psw};
            OP_TRET:  next_ctx = '{pc: ct_ctx.pc,   psw: ct_ctx.psw};
            OP_DTRAP: next_ctx = '{pc: TRAP_VEC,    psw: db_ctx.psw | TRAP_MASK};
            default:  next_ctx = '{pc: db_ctx.pc,   psw: db_ctx.psw};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            data_q  <= '0;
            tgt_q   <= '0;
            out_ctx <= '0;
            done    <= 1'b0;
        end else begin
            if (accept) idx_q <= op_index;
            if (fetch_en && mem_ready) data_q <= mem_rdata;
            if (add_en) tgt_q <= clr_lsb(base_q + {{(XLEN-HW_W){1'b0}}, data_q});
            if (finish) begin
                out_ctx.pc  <= clr_lsb(next_ctx.pc);
                out_ctx.psw <= next_ctx.psw;
            end
            done <= finish;
        end
    end

    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: result holds between pulses
    a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(out_ctx));

    // R10: even program counter on every result
    a_r10_pc_even: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_ctx.pc[0]);

    // R7: a finished trap points at the vector with the three bits set
    a_r7_trap_vec: assert property (@(posedge clk) disable iff (rst)
        done && op_q == OP_DTRAP |-> out_ctx.pc == clr_lsb(TRAP_VEC)
                                     && (out_ctx.psw & TRAP_MASK) == TRAP_MASK);

endmodule

// File: rtl/tcall_dtrap_unit.sv
module tcall_dtrap_unit
    import tcd_pkg::*;
#(
    parameter int          IDX_W       = 6,
    parameter int          HW_W        = 16,
    parameter int          CALL_CYCLES = 5,
    parameter int          RET_CYCLES  = 4,
    parameter logic [31:0] BASE_RST    = 32'h0,
    parameter logic [31:0] TRAP_VEC    = 32'h0000_0060
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [IDX_W-1:0] op_index,
    input  logic [31:0]      cur_pc,
    input  logic [31:0]      cur_psw,
    input  logic             base_load,
    input  logic [31:0]      base_value,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic [HW_W-1:0]  mem_rdata,
    input  logic             mem_ready,
    output logic [31:0]      new_pc,
    output logic [31:0]      new_psw,
    output logic             done
);
    op_e             kind;
    op_e             op_q;
    logic            accept;
    logic            fetch_en;
    logic            add_en;
    logic            finish;
    ctx_t            ct_ctx;
    ctx_t            db_ctx;
    ctx_t            out_ctx;
    logic [XLEN-1:0] base_q;

    assign kind = op_e'(op_kind);

    tcd_sequencer #(
        .CALL_CYCLES(CALL_CYCLES),
        .RET_CYCLES (RET_CYCLES),
        .FETCH_STEP (2)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_kind  (kind),
        .mem_ready(mem_ready),
        .accept   (accept),
        .op_q     (op_q),
        .fetch_en (fetch_en),
        .add_en   (add_en),
        .finish   (finish)
    );

    tcd_save_bank #(
        .BASE_RST(BASE_RST)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .op_kind   (kind),
        .cur_pc    (cur_pc),
        .cur_psw   (cur_psw),
        .base_load (base_load),
        .base_value(base_value),
        .ct_ctx    (ct_ctx),
        .db_ctx    (db_ctx),
        .base_q    (base_q)
    );

    tcd_pc_unit #(
        .IDX_W   (IDX_W),
        .HW_W    (HW_W),
        .TRAP_VEC(TRAP_VEC)
    ) u_pcu (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .op_index (op_index),
        .op_q     (op_q),
        .fetch_en (fetch_en),
        .add_en   (add_en),
        .finish   (finish),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .base_q   (base_q),
        .ct_ctx   (ct_ctx),
        .db_ctx   (db_ctx),
        .mem_addr (mem_addr),
        .out_ctx  (out_ctx),
        .done     (done)
    );

    assign mem_req = fetch_en;
    assign new_pc  = out_ctx.pc;
    assign new_psw = out_ctx.psw;

    // R3: a read request belongs only to a running table call
    a_r3_req_call_only: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> op_q == OP_TCALL && !done);

    // R3: the address does not move while a request waits, unless the base is rewritten
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready && !base_load |=> $stable(mem_addr));

endmodule

// File: tb/tcall_dtrap_unit_tb.sv
module tcall_dtrap_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [5:0]  op_index = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psw = '0;
    logic        base_load = 1'b0;
    logic [31:0] base_value = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_ready = 1'b0;
    logic [31:0] new_pc;
    logic [31:0] new_psw;
    logic        done;

    int checks = 0;
    int errors = 0;
    int mem_wait = 0;
    int wcnt = 0;
    int req_cycles = 0;
    logic [31:0] seen_addr = '0;
    logic [31:0] base_m = '0;

    always #4 clk = ~clk;

    tcall_dtrap_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_index(op_index), .cur_pc(cur_pc), .cur_psw(cur_psw),
        .base_load(base_load), .base_value(base_value),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .new_pc(new_pc), .new_psw(new_psw), .done(done)
    );

    function automatic logic [15:0] table_word(input logic [31:0] a);
        return a[15:0] ^ 16'h5A5B;
    endfunction

    assign mem_rdata = table_word(mem_addr);

    always @(negedge clk) begin
        if (mem_req) begin
            seen_addr = mem_addr;
            req_cycles++;
            if (wcnt < mem_wait) begin
                mem_ready = 1'b0;
                wcnt++;
            end else begin
                mem_ready = 1'b1;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic count_done(output int cyc);
        cyc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            cyc++;
            if (done) break;
        end
    endtask

    task automatic load_base(input logic [31:0] v);
        @(negedge clk);
        base_load = 1'b1;
        base_value = v;
        @(negedge clk);
        base_load = 1'b0;
        base_m = v;
    endtask

    task automatic run_op(input logic [1:0] kind, input logic [5:0] idx,
                          input logic [31:0] pc, input logic [31:0] psw,
                          input int wait_n, input int exp_cyc,
                          input logic [31:0] exp_pc, input logic [31:0] exp_psw,
                          input string tag);
        int cyc;
        logic [31:0] held;
        mem_wait = wait_n;
        req_cycles = 0;
        @(negedge clk);
        op_valid = 1'b1;
        op_kind = kind;
        op_index = idx;
        cur_pc = pc;
        cur_psw = psw;
        count_done(cyc);
        cur_pc = 32'hDEAD_BEEF;
        cur_psw = 32'h0BAD_0BAD;
        check({tag, " cycles"}, cyc, exp_cyc);
        check({tag, " new_pc"}, new_pc, exp_pc);
        check({tag, " new_psw"}, new_psw, exp_psw);
        if (kind == 2'b00) begin
            check({tag, " R3 addr"}, seen_addr, base_m + {25'd0, idx, 1'b0});
            check({tag, " R5 one request"}, req_cycles, wait_n + 1);
        end else begin
            check({tag, " R9 no request"}, req_cycles, 0);
        end
        held = new_pc;
        @(negedge clk);
        check({tag, " R10 done low"}, {31'd0, done}, 32'd0);
        check({tag, " R10 pc held"}, new_pc, held);
    endtask

    // R9: strobes while busy are dropped, a strobe in the done cycle is taken
    task automatic busy_overlap(input logic [31:0] old_dbpc, input logic [31:0] old_dbpsw);
        int cyc;
        logic [31:0] exp_pc;
        mem_wait = 1;
        @(negedge clk);
        op_valid = 1'b1;
        op_kind = 2'b00;
        op_index = 6'd1;
        cur_pc = 32'h5000;
        cur_psw = 32'h3;
        cyc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cyc++;
            if (done) break;
            op_valid = 1'b1;
            op_kind = 2'b10;
            cur_pc = 32'h7777;
            cur_psw = 32'hFF00;
        end
        exp_pc = (base_m + {16'd0, table_word(base_m + 32'd2)}) & ~32'd1;
        check("R9 call cycles under strobes", cyc, 6);
        check("R9 call pc under strobes", new_pc, exp_pc);
        op_valid = 1'b1;
        op_kind = 2'b11;
        count_done(cyc);
        check("R9 accepted in done cycle R8 cycles", cyc, 4);
        check("R9 debug pc untouched", new_pc, old_dbpc);
        check("R9 debug psw untouched", new_psw, old_dbpsw);
    endtask

    initial begin
        int lim = 0;
        while (lim < 20000) begin
            @(posedge clk);
            lim++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done", {31'd0, done}, 0);
        check("R1 mem_req", {31'd0, mem_req}, 0);
        check("R1 new_pc", new_pc, 0);
        check("R1 new_psw", new_psw, 0);
        check("R1 base addr", mem_addr, 0);

        // R11 base load, R2 R4 R5 call
        load_base(32'h1000);
        run_op(2'b00, 6'd5, 32'h2001, 32'h11, 0, 5,
               (32'h1000 + {16'd0, table_word(32'h100A)}) & ~32'd1, 32'h11, "R4 R5 call");
        // R6 return restores PC+2 (bit0 cleared), R2
        run_op(2'b01, 6'd0, 32'h9999, 32'h0, 0, 4, 32'h2002, 32'h11, "R2 R6 ret");
        // R5 stalled call at the top index
        run_op(2'b00, 6'd63, 32'h3000, 32'h2, 3, 8,
               (32'h1000 + {16'd0, table_word(32'h107E)}) & ~32'd1, 32'h2, "R3 R5 stall call");
        // R7 trap
        run_op(2'b10, 6'd0, 32'h4444, 32'h1, 0, 4, 32'h60, 32'hE1, "R7 trap");
        // R8 debug return
        run_op(2'b11, 6'd0, 32'h0, 32'h0, 0, 4, 32'h4446, 32'h1, "R8 dret");
        // R9 overlap
        busy_overlap(32'h4446, 32'h1);
        // R11 reload base
        load_base(32'h8000);
        run_op(2'b00, 6'd0, 32'hA000, 32'h40, 1, 6,
               (32'h8000 + {16'd0, table_word(32'h8000)}) & ~32'd1, 32'h40, "R11 new base");
        run_op(2'b01, 6'd0, 32'h0, 32'h0, 0, 4, 32'hA002, 32'h40, "R6 ret after reload");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule